// File: doc/BRIEF.md
# Table Pointer and Write Buffer Unit

This unit moves single bytes between program memory and the data side of a small processor core. It keeps a 22-bit byte pointer, which software loads and reads one byte lane at a time, and an 8-bit transfer latch. A table read fetches the byte at the pointer through a fixed-latency program-memory read port and places it in the latch. A table write copies the latch into one of 64 holding registers. Each table operation also steps the pointer in one of four ways. Increment and decrement affect only the low 21 bits. Bit 21 stays where software put it, and it selects the identification and configuration space.

Table operations arrive on a valid/ready request channel. The unit accepts a request on any clock edge where `op_valid` and `op_ready` are both high. A read holds `op_ready` low for two cycles: one cycle to issue the address and one to capture the data. A write completes at its accepting edge, so a requester may present one write per cycle. When a request is refused, the requester keeps `op_valid` and the request fields steady. `op_done` is high in each cycle that follows a completed operation, and in that cycle the latch and the pointer already show the result. The program-memory port applies no back-pressure. Data is expected one cycle after the address is issued.

When the controller starts a row write or an erase, the unit returns a one-cycle strobe. The strobe carries the 64-byte row number or the 1024-byte block number, both taken from the pointer. The flash timing engine, the flash array and the instruction decoder are outside this unit.

Top module: `prog_table_unit`

## Requirements
- R1: After reset the pointer reads zero. With `ptr_wr_en` high, `ptr_wr_sel` picks a byte lane: 0 writes pointer bits 7:0, 1 writes bits 15:8, 2 writes bits 21:16 from data bits 5:0, and 3 writes nothing. The written byte shows on `ptr_value` in the next cycle.
- R2: The unit accepts a request on an edge where `op_valid` and `op_ready` are both high. `op_ready` is low while a read is in progress. A read raises `op_done` two cycles after its accepting edge. A write raises `op_done` in the cycle right after its accepting edge.
- R3: `op_mode` sets how the pointer moves. 0 leaves it unchanged. 1 increments it after the access and 2 decrements it after the access, and in both cases the access uses the old value. 3 increments it first, and the access uses the new value.
- R4: Increment and decrement change only pointer bits 20:0, which wrap within 21 bits. Bit 21 keeps its value.
- R5: A read (`op_kind`=0) drives `mem_rd_en` for exactly one cycle with all 22 access-address bits on `mem_addr`. The byte returned on the next cycle goes into the latch, and it appears on `latch_q` in the same cycle as `op_done`.
- R6: A write (`op_kind`=1) stores the latch byte into the holding register that access-address bits 5:0 select. Any holding register can be read back through `hold_rd_idx`/`hold_rd_data`.
- R7: A `row_go` pulse makes `row_strobe` high for one cycle on the next cycle. In that cycle `row_addr` holds pointer bits 20:6.
- R8: An `erase_go` pulse makes `erase_strobe` high for one cycle on the next cycle. In that cycle `erase_addr` holds pointer bits 20:10. Pointer bits 9:0 have no effect on it.
- R9: When a bus write to a pointer byte lane falls in the same cycle as a pointer update from a table operation, the bus byte wins in that lane. The other lanes take the updated value.
- R10: After reset the latch and all 64 holding registers are zero. `lat_wr_en` loads `lat_wr_data` into the latch, and `latch_q` shows it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ptr_wr_en | input | 1 | Write a pointer byte lane |
| ptr_wr_sel | input | 2 | Lane: 0 low, 1 high, 2 upper |
| ptr_wr_data | input | 8 | Lane write data |
| ptr_value | output | 22 | Current pointer |
| lat_wr_en | input | 1 | Load the latch from the bus |
| lat_wr_data | input | 8 | Latch load data |
| latch_q | output | 8 | Current latch byte |
| op_valid | input | 1 | Table operation request |
| op_ready | output | 1 | Request can be accepted |
| op_kind | input | 1 | 0 read, 1 write |
| op_mode | input | 2 | Pointer step mode |
| op_done | output | 1 | Operation finished |
| mem_rd_en | output | 1 | Program-memory read strobe |
| mem_addr | output | 22 | Program-memory byte address |
| mem_rd_data | input | 8 | Byte returned one cycle after strobe |
| hold_rd_idx | input | 6 | Holding register to read out |
| hold_rd_data | output | 8 | Selected holding register |
| row_go | input | 1 | Start of a row write |
| row_strobe | output | 1 | Row address valid |
| row_addr | output | 15 | 64-byte row number |
| erase_go | input | 1 | Start of an erase |
| erase_strobe | output | 1 | Erase address valid |
| erase_addr | output | 11 | 1024-byte block number |

## Verification
The bench builds the unit with its default parameters: a 22-bit pointer, 64 holding registers and 1024-byte erase blocks. These are the widths that set the field boundaries. Bench writes to the lanes can place the pointer at 0x1FFFFF or 0x200000, so the 21-bit wrap in both directions is reached in one step. With the same widths, a 6-bit holding index and an 11-bit block number can be matched against values the bench computes from the pointer. A scoreboard holds the expected latch and pointer for each operation, in every step mode, including a lane write that collides with a pointer update.

// File: rtl/prog_table_pkg.sv
package prog_table_pkg;
  typedef enum logic [1:0] {
    STEP_KEEP     = 2'd0,
    STEP_POST_INC = 2'd1,
    STEP_POST_DEC = 2'd2,
    STEP_PRE_INC  = 2'd3
  } step_mode_e;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ISSUE   = 2'd1,
    SEQ_CAPTURE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/prog_table_ptr.sv
module prog_table_ptr #(
  parameter int PTR_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_sel,
  input  logic [7:0]       bus_data,
  input  logic             upd_en,
  input  logic [PTR_W-1:0] upd_val,
  output logic [PTR_W-1:0] ptr_q
);
  localparam int UPPER_W = PTR_W - 16;

  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = upd_en ? upd_val : ptr_q;
    if (bus_we) begin
      case (bus_sel)
        2'd0:    ptr_nxt[7:0]        = bus_data;
        2'd1:    ptr_nxt[15:8]       = bus_data;
        2'd2:    ptr_nxt[PTR_W-1:16] = bus_data[UPPER_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/prog_table_hold.sv
module prog_table_hold #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            slot[i] <= '0;
      else if (we && widx == IDX_W'(i))      slot[i] <= wdata;
    end
  end

  assign rdata = slot[ridx];
endmodule

// File: rtl/prog_table_seq.sv
module prog_table_seq
  import prog_table_pkg::*;
#(
  parameter int PTR_W = 22,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] ptr_q,
  input  logic             op_valid,
  input  acc_kind_e        op_kind,
  input  step_mode_e       op_mode,
  output logic             op_ready,
  output logic             op_done,
  input  logic             lat_we,
  input  logic [7:0]       lat_wdata,
  output logic [7:0]       latch_q,
  output logic             mem_rd_en,
  output logic [PTR_W-1:0] mem_addr,
  input  logic [7:0]       mem_rd_data,
  output logic             hold_we,
  output logic [IDX_W-1:0] hold_idx,
  output logic [7:0]       hold_data,
  output logic             upd_en,
  output logic [PTR_W-1:0] upd_val
);
  localparam int STEP_W = PTR_W - 1;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p, input logic down);
    logic [STEP_W-1:0] low;
    low = down ? p[STEP_W-1:0] - STEP_W'(1) : p[STEP_W-1:0] + STEP_W'(1);
    return {p[PTR_W-1], low};
  endfunction

  seq_state_e       state;
  step_mode_e       mode_r;
  logic [PTR_W-1:0] acc_r;
  logic [PTR_W-1:0] ptr_inc, ptr_dec, acc_now;
  logic             accept;

  assign op_ready  = (state == SEQ_IDLE);
  assign accept    = op_valid && op_ready;
  assign ptr_inc   = step_ptr(ptr_q, 1'b0);
  assign ptr_dec   = step_ptr(ptr_q, 1'b1);
  assign acc_now   = (op_mode == STEP_PRE_INC) ? ptr_inc : ptr_q;

  assign hold_we   = accept && (op_kind == ACC_WRITE);
  assign hold_idx  = acc_now[IDX_W-1:0];
  assign hold_data = latch_q;

  assign mem_rd_en = (state == SEQ_ISSUE);
  assign mem_addr  = acc_r;

  always_comb begin
    upd_en  = 1'b0;
    upd_val = ptr_q;
    if (accept) begin
      if (op_mode == STEP_PRE_INC) begin
        upd_en = 1'b1; upd_val = ptr_inc;
      end else if (op_kind == ACC_WRITE && op_mode == STEP_POST_INC) begin
        upd_en = 1'b1; upd_val = ptr_inc;
      end else if (op_kind == ACC_WRITE && op_mode == STEP_POST_DEC) begin
        upd_en = 1'b1; upd_val = ptr_dec;
      end
    end else if (state == SEQ_CAPTURE) begin
      if (mode_r == STEP_POST_INC) begin
        upd_en = 1'b1; upd_val = ptr_inc;
      end else if (mode_r == STEP_POST_DEC) begin
        upd_en = 1'b1; upd_val = ptr_dec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      mode_r  <= STEP_KEEP;
      acc_r   <= '0;
      latch_q <= '0;
      op_done <= 1'b0;
    end else begin
      op_done <= hold_we || (state == SEQ_CAPTURE);
      case (state)
        SEQ_IDLE: if (accept && op_kind == ACC_READ) begin
          acc_r  <= acc_now;
          mode_r <= op_mode;
          state  <= SEQ_ISSUE;
        end
        SEQ_ISSUE:   state <= SEQ_CAPTURE;
        SEQ_CAPTURE: state <= SEQ_IDLE;
        default:     state <= SEQ_IDLE;
      endcase
      if (lat_we)                      latch_q <= lat_wdata;
      else if (state == SEQ_CAPTURE)   latch_q <= mem_rd_data;
    end
  end
endmodule

// File: rtl/prog_table_unit.sv
module prog_table_unit
  import prog_table_pkg::*;
#(
  parameter int PTR_W   = 22,
  parameter int IDX_W   = 6,
  parameter int BLOCK_W = 10,
  localparam int STEP_W = PTR_W - 1,
  localparam int ROW_W  = STEP_W - IDX_W,
  localparam int BLK_W  = STEP_W - BLOCK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr_en,
  input  logic [1:0]        ptr_wr_sel,
  input  logic [7:0]        ptr_wr_data,
  output logic [PTR_W-1:0]  ptr_value,
  input  logic              lat_wr_en,
  input  logic [7:0]        lat_wr_data,
  output logic [7:0]        latch_q,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_kind,
  input  logic [1:0]        op_mode,
  output logic              op_done,
  output logic              mem_rd_en,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic [IDX_W-1:0]  hold_rd_idx,
  output logic [7:0]        hold_rd_data,
  input  logic              row_go,
  output logic              row_strobe,
  output logic [ROW_W-1:0]  row_addr,
  input  logic              erase_go,
  output logic              erase_strobe,
  output logic [BLK_W-1:0]  erase_addr
);
  logic             upd_en, hold_we;
  logic [PTR_W-1:0] upd_val;
  logic [IDX_W-1:0] hold_idx;
  logic [7:0]       hold_data;

  prog_table_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .bus_we(ptr_wr_en), .bus_sel(ptr_wr_sel), .bus_data(ptr_wr_data),
    .upd_en(upd_en), .upd_val(upd_val), .ptr_q(ptr_value)
  );

  prog_table_seq #(.PTR_W(PTR_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ptr_q(ptr_value),
    .op_valid(op_valid), .op_kind(acc_kind_e'(op_kind)), .op_mode(step_mode_e'(op_mode)),
    .op_ready(op_ready), .op_done(op_done),
    .lat_we(lat_wr_en), .lat_wdata(lat_wr_data), .latch_q(latch_q),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .hold_we(hold_we), .hold_idx(hold_idx), .hold_data(hold_data),
    .upd_en(upd_en), .upd_val(upd_val)
  );

  prog_table_hold #(.IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .we(hold_we), .widx(hold_idx), .wdata(hold_data),
    .ridx(hold_rd_idx), .rdata(hold_rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_strobe   <= 1'b0;
      row_addr     <= '0;
      erase_strobe <= 1'b0;
      erase_addr   <= '0;
    end else begin
      row_strobe   <= row_go;
      erase_strobe <= erase_go;
      if (row_go)   row_addr   <= ptr_value[STEP_W-1:IDX_W];
      if (erase_go) erase_addr <= ptr_value[STEP_W-1:BLOCK_W];
    end
  end
endmodule

// File: rtl/prog_table_chk.sv
module prog_table_chk #(
  parameter int PTR_W   = 22,
  parameter int IDX_W   = 6,
  parameter int BLOCK_W = 10,
  localparam int STEP_W = PTR_W - 1,
  localparam int ROW_W  = STEP_W - IDX_W,
  localparam int BLK_W  = STEP_W - BLOCK_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic             op_kind,
  input logic             op_done,
  input logic             mem_rd_en,
  input logic             ptr_wr_en,
  input logic [1:0]       ptr_wr_sel,
  input logic [PTR_W-1:0] ptr_value,
  input logic             row_go,
  input logic             row_strobe,
  input logic [ROW_W-1:0] row_addr,
  input logic             erase_go,
  input logic             erase_strobe,
  input logic [BLK_W-1:0] erase_addr
);
  AST_READ_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_kind) |=> (mem_rd_en && !op_ready)); // R2
  AST_ISSUE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R5
  AST_READ_DONE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> ##1 op_done); // R5
  AST_BIT21_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_wr_en && ptr_wr_sel == 2'd2) |=> ptr_value[PTR_W-1] == $past(ptr_value[PTR_W-1])); // R4
  AST_ROW_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    row_go |=> (row_strobe && row_addr == $past(ptr_value[STEP_W-1:IDX_W]))); // R7
  AST_ERASE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (erase_strobe && erase_addr == $past(ptr_value[STEP_W-1:BLOCK_W]))); // R8
endmodule

bind prog_table_unit prog_table_chk #(.PTR_W(PTR_W), .IDX_W(IDX_W), .BLOCK_W(BLOCK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
  .op_done(op_done), .mem_rd_en(mem_rd_en), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
  .ptr_value(ptr_value), .row_go(row_go), .row_strobe(row_strobe), .row_addr(row_addr),
  .erase_go(erase_go), .erase_strobe(erase_strobe), .erase_addr(erase_addr)
);

// File: tb/test_prog_table_unit.sv
`timescale 1ns/1ps
module test_prog_table_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr_en = 1'b0;
  logic [1:0]  ptr_wr_sel = '0;
  logic [7:0]  ptr_wr_data = '0;
  logic [21:0] ptr_value;
  logic        lat_wr_en = 1'b0;
  logic [7:0]  lat_wr_data = '0;
  logic [7:0]  latch_q;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic        op_kind = 1'b0;
  logic [1:0]  op_mode = '0;
  logic        op_done;
  logic        mem_rd_en;
  logic [21:0] mem_addr;
  logic [7:0]  mem_rd_data = '0;
  logic [5:0]  hold_rd_idx = '0;
  logic [7:0]  hold_rd_data;
  logic        row_go = 1'b0;
  logic        row_strobe;
  logic [14:0] row_addr;
  logic        erase_go = 1'b0;
  logic        erase_strobe;
  logic [10:0] erase_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [21:0] m_ptr = '0;
  logic [7:0]  m_lat = '0;
  logic [7:0]  m_hold [64];
  logic [7:0]  exp_lat_q [$];
  logic [21:0] exp_ptr_q [$];
  string       exp_tag_q [$];

  always #4 clk = ~clk;

  prog_table_unit i_prog_table_unit (
    .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
    .ptr_wr_data(ptr_wr_data), .ptr_value(ptr_value), .lat_wr_en(lat_wr_en),
    .lat_wr_data(lat_wr_data), .latch_q(latch_q), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_mode(op_mode), .op_done(op_done), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .hold_rd_idx(hold_rd_idx),
    .hold_rd_data(hold_rd_data), .row_go(row_go), .row_strobe(row_strobe),
    .row_addr(row_addr), .erase_go(erase_go), .erase_strobe(erase_strobe),
    .erase_addr(erase_addr)
  );

  function automatic logic [7:0] mem_byte(input logic [21:0] a);
    return a[7:0] ^ {a[15:10], a[21:20]} ^ 8'h5A;
  endfunction

  function automatic logic [21:0] step(input logic [21:0] p, input bit down);
    logic [20:0] low;
    low = down ? p[20:0] - 21'd1 : p[20:0] + 21'd1;
    return {p[21], low};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_byte(mem_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every completion is compared with the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && op_done) begin
      if (exp_lat_q.size() == 0) begin
        chk(1'b0, "R2 unexpected op_done", 32'(op_done), 32'd0);
      end else begin
        logic [7:0]  el;
        logic [21:0] ep;
        string       et;
        el = exp_lat_q.pop_front();
        ep = exp_ptr_q.pop_front();
        et = exp_tag_q.pop_front();
        chk(latch_q == el, {et, " latch"}, 32'(latch_q), 32'(el));
        chk(ptr_value == ep, {et, " pointer"}, 32'(ptr_value), 32'(ep));
      end
    end
  end

  task automatic set_lane(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_sel = sel; ptr_wr_data = d;
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] v);
    set_lane(2'd0, v[7:0]);
    set_lane(2'd1, v[15:8]);
    set_lane(2'd2, {2'b00, v[21:16]});
    m_ptr = v;
  endtask

  task automatic set_lat(input logic [7:0] v);
    @(negedge clk);
    lat_wr_en = 1'b1; lat_wr_data = v;
    @(negedge clk);
    lat_wr_en = 1'b0;
    m_lat = v;
    chk(latch_q == v, "R10 latch bus load", 32'(latch_q), 32'(v));
  endtask

  // Driver: computes the expected outcome, queues it, then issues the request.
  task automatic run_op(input bit kind, input logic [1:0] mode, input string tag,
                        input bit collide = 0, input logic [7:0] col_byte = '0);
    logic [21:0] acc;
    logic [21:0] nxt;
    acc = (mode == 2'd3) ? step(m_ptr, 0) : m_ptr;
    case (mode)
      2'd1, 2'd3: nxt = step(m_ptr, 0);
      2'd2:       nxt = step(m_ptr, 1);
      default:    nxt = m_ptr;
    endcase
    if (collide) nxt[7:0] = col_byte;
    if (kind) m_hold[acc[5:0]] = m_lat;
    else      m_lat = mem_byte(acc);
    m_ptr = nxt;
    exp_lat_q.push_back(m_lat);
    exp_ptr_q.push_back(m_ptr);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_kind = kind; op_mode = mode;
    if (collide) begin
      ptr_wr_en = 1'b1; ptr_wr_sel = 2'd0; ptr_wr_data = col_byte;
    end
    @(negedge clk);
    op_valid = 1'b0; ptr_wr_en = 1'b0;
    if (!kind) begin
      chk(mem_rd_en && !op_ready, "R2 busy during read issue", 32'({mem_rd_en, op_ready}), 32'h2);
      chk(mem_addr == acc, "R5 read address", 32'(mem_addr), 32'(acc));
    end
    while (exp_lat_q.size() != 0) @(posedge clk);
  endtask

  task automatic chk_hold(input logic [5:0] idx, input string tag);
    @(negedge clk);
    hold_rd_idx = idx;
    #1;
    chk(hold_rd_data == m_hold[idx], tag, 32'(hold_rd_data), 32'(m_hold[idx]));
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    for (int i = 0; i < 64; i++) m_hold[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    chk(ptr_value == '0, "R1 reset pointer", 32'(ptr_value), 32'd0);
    chk(latch_q == '0, "R10 reset latch", 32'(latch_q), 32'd0);
    chk(op_ready && !op_done, "R2 idle after reset", 32'({op_ready, op_done}), 32'h2);
    chk_hold(6'd0, "R10 reset hold 0");
    chk_hold(6'd63, "R10 reset hold 63");

    // R1 lane writes, including the unused lane select
    set_ptr(22'h2A_5C3E);
    chk(ptr_value == 22'h2A_5C3E, "R1 lane readback", 32'(ptr_value), 32'h2A5C3E);
    set_lane(2'd3, 8'hFF);
    chk(ptr_value == 22'h2A_5C3E, "R1 select 3 ignored", 32'(ptr_value), 32'h2A5C3E);

    // R3 / R5 reads in all modes
    set_ptr(22'h01_2340);
    run_op(1'b0, 2'd0, "R3 read keep");
    run_op(1'b0, 2'd1, "R3 read post-inc");
    run_op(1'b0, 2'd2, "R3 read post-dec");
    run_op(1'b0, 2'd3, "R3 read pre-inc");

    // R4 wrap within 21 bits, bit 21 kept; R5 bit 21 in address
    set_ptr(22'h1F_FFFF);
    run_op(1'b0, 2'd1, "R4 wrap up bit21 clear");
    set_ptr(22'h20_0000);
    run_op(1'b0, 2'd2, "R4 wrap down bit21 set");
    set_ptr(22'h3F_FFFF);
    run_op(1'b0, 2'd3, "R4 pre-inc wrap bit21 set");

    // R6 writes fill the holding buffer
    set_ptr(22'h00_013E);
    set_lat(8'hA1);
    run_op(1'b1, 2'd1, "R6 write post-inc");
    set_lat(8'hB2);
    run_op(1'b1, 2'd1, "R6 write post-inc carry");
    set_lat(8'hC3);
    run_op(1'b1, 2'd3, "R6 write pre-inc");
    set_lat(8'hD4);
    run_op(1'b1, 2'd2, "R6 write post-dec");
    set_lat(8'hE5);
    run_op(1'b1, 2'd0, "R6 write keep");
    chk_hold(6'h3E, "R6 hold 0x3E");
    chk_hold(6'h3F, "R6 hold 0x3F");
    chk_hold(6'h01, "R6 hold 0x01");
    chk_hold(6'h00, "R6 hold 0x00");
    chk_hold(6'h02, "R6 hold untouched");

    // R9 lane write collides with a pointer update
    set_ptr(22'h00_0F10);
    set_lat(8'h77);
    run_op(1'b1, 2'd1, "R9 bus lane wins", 1'b1, 8'h55);
    chk_hold(6'h10, "R9 hold at old index");

    // R7 / R8 row and erase strobes
    set_ptr(22'h2A_BCDE);
    @(negedge clk);
    row_go = 1'b1; erase_go = 1'b1;
    @(negedge clk);
    row_go = 1'b0; erase_go = 1'b0;
    chk(row_strobe && row_addr == 15'(22'h0A_BCDE >> 6), "R7 row strobe address",
        32'({row_strobe, row_addr}), 32'({1'b1, 15'(22'h0A_BCDE >> 6)}));
    chk(erase_strobe && erase_addr == 11'(22'h0A_BCDE >> 10), "R8 erase strobe address",
        32'({erase_strobe, erase_addr}), 32'({1'b1, 11'(22'h0A_BCDE >> 10)}));
    @(negedge clk);
    chk(!row_strobe && !erase_strobe, "R7 R8 single-cycle strobes",
        32'({row_strobe, erase_strobe}), 32'd0);
    set_ptr(22'h2A_BC01);
    @(negedge clk);
    erase_go = 1'b1;
    @(negedge clk);
    erase_go = 1'b0;
    chk(erase_addr == 11'(22'h0A_BCDE >> 10), "R8 low bits ignored",
        32'(erase_addr), 32'(11'(22'h0A_BCDE >> 10)));

    repeat (4) @(negedge clk);
    chk(exp_lat_q.size() == 0, "R2 all completions seen", 32'(exp_lat_q.size()), 32'd0);
    report();
  end
endmodule